// File: doc/BRIEF.md
# Sign-Agreement Power Flow Direction Detector

This block decides which way real power flows through a feeder. Two upstream comparators reduce the voltage and current waveforms to their sign bits, and a strobe marks each sample instant. Each sample is scored +1 when the two signs match and -1 when they differ. The scores are summed in a saturating signed integrator over a window whose length in samples is set at a port.

When power flows forward, voltage and current sit within a quarter cycle of each other, so matching-sign stretches outweigh opposed ones and the window sum is positive. When power flows in reverse, the sum goes negative. At the close of every window, the block reports the sign of the sum as a direction flag. If the sum lies below the negative of a programmed threshold, it raises a breaker trip. The trip stays latched until a clear pulse arrives, and the integrator then restarts from zero for the next window.

Top module: `flow_dir_relay`

## Requirements
- R1: After reset, `trip` is 0, `dir_fwd` is 1 and `win_done` is 0.
- R2: A sign input of 1 means the quantity is negative. On a strobed sample, equal `v_neg` and `i_neg` add +1 to the integrator and unequal ones add -1.
- R3: The integrator saturates at 2^(CNT_W-1)-1 and at -2^(CNT_W-1). It never wraps.
- R4: A window closes on its `win_len`-th strobed sample, and a `win_len` of 0 acts as 1. `win_done` is 1 for exactly the cycle after that sample's clock edge. The next window starts from a sum of zero.
- R5: At each window close, `dir_fwd` becomes 1 if the final sum is at least 0 and 0 otherwise. It holds its value between closes.
- R6: At a window close, `trip` sets when the final sum is strictly less than minus `thresh`, where `thresh` is unsigned.
- R7: `trip` stays set until `trip_clr` is 1 on a clock edge. When a clear coincides with a window close that sets trip, trip stays set.
- R8: Cycles with `sample_en` low change neither the integrator nor the sample count within the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Strobe: one sample is taken this cycle |
| v_neg | input | 1 | Voltage sign, 1 = negative |
| i_neg | input | 1 | Current sign, 1 = negative |
| win_len | input | WIN_W | Samples per window (0 treated as 1) |
| thresh | input | CNT_W | Reverse-flow trip margin, unsigned |
| trip_clr | input | 1 | Clears the latched trip |
| trip | output | 1 | Latched breaker trip |
| dir_fwd | output | 1 | 1 = last window showed forward flow |
| win_done | output | 1 | One-cycle pulse after each window close |

## Verification
The hardest state to reach is a saturated integrator whose clamped value changes the decision. Only the final sum is visible, and only through `dir_fwd` and `trip`. The bench drives square waves with every phase offset over one period, using windows longer than the counter range. A long run of opposed signs pins the sum at its minimum, and the agreeing tail that follows then lands the sum on a different side of the threshold than unclamped arithmetic would. Gaps without a strobe and clears that coincide with a trip are mixed into the same runs.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic {
        PROD_MINUS = 1'b0,
        PROD_PLUS  = 1'b1
    } prod_e;
endpackage

// File: rtl/pfd_sign_product.sv
module pfd_sign_product
    import pfd_pkg::*;
(
    input  logic  v_neg,
    input  logic  i_neg,
    output prod_e prod
);
    // Signs that agree score +1 (R2).
    always_comb begin
        prod = (v_neg == i_neg) ? PROD_PLUS : PROD_MINUS;
    end
endmodule

// File: rtl/pfd_integrator.sv
module pfd_integrator
    import pfd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  prod_e                   prod,
    input  logic [WIN_W-1:0]        win_len,
    output logic                    win_end,
    output logic signed [CNT_W-1:0] win_sum
);
    localparam logic signed [CNT_W-1:0] ACC_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] ACC_MIN = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic signed [CNT_W-1:0] acc;
        logic [WIN_W-1:0]        cnt;
    } integ_t;

    integ_t st_d, st_q;
    logic signed [CNT_W-1:0] step_d;
    logic [WIN_W:0]          lim_d;
    logic [WIN_W:0]          seen_d;

    always_comb begin
        st_d   = st_q;
        lim_d  = (win_len == '0) ? (WIN_W+1)'(1) : {1'b0, win_len};
        seen_d = {1'b0, st_q.cnt} + (WIN_W+1)'(1);
        if (prod == PROD_PLUS) begin
            step_d = (st_q.acc == ACC_MAX) ? ACC_MAX : st_q.acc + CNT_W'(1);
        end else begin
            step_d = (st_q.acc == ACC_MIN) ? ACC_MIN : st_q.acc - CNT_W'(1);
        end
        win_end = sample_en && (seen_d >= lim_d);
        win_sum = step_d;
        if (sample_en) begin
            if (win_end) begin
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = step_d;
                st_d.cnt = seen_d[WIN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(st_q.acc) && $stable(st_q.cnt));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (st_q.acc == '0) && (st_q.cnt == '0));

    p_sat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !win_end && prod == PROD_PLUS && st_q.acc == ACC_MAX)
        |=> st_q.acc == ACC_MAX);

    p_sat_bot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !win_end && prod == PROD_MINUS && st_q.acc == ACC_MIN)
        |=> st_q.acc == ACC_MIN);
endmodule

// File: rtl/pfd_decide.sv
module pfd_decide #(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    win_end,
    input  logic signed [CNT_W-1:0] win_sum,
    input  logic [CNT_W-1:0]        thresh,
    input  logic                    trip_clr,
    output logic                    trip,
    output logic                    dir_fwd,
    output logic                    win_done
);
    typedef struct packed {
        logic trip;
        logic dir;
        logic done;
    } dec_t;

    dec_t st_d, st_q;
    logic signed [CNT_W+1:0] margin_d;

    always_comb begin
        st_d      = st_q;
        // sum < -thresh  <=>  sum + thresh < 0, done one bit wider
        margin_d  = (CNT_W+2)'(win_sum) + $signed({2'b00, thresh});
        st_d.done = win_end;
        if (trip_clr) st_d.trip = 1'b0;
        if (win_end) begin
            st_d.dir = !win_sum[CNT_W-1];
            if (margin_d[CNT_W+1]) st_d.trip = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{trip: 1'b0, dir: 1'b1, done: 1'b0};
        else        st_q <= st_d;
    end

    assign trip     = st_q.trip;
    assign dir_fwd  = st_q.dir;
    assign win_done = st_q.done;

    p_trip_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> win_done);

    p_trip_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !trip_clr) |=> trip);

    p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(dir_fwd));
endmodule

// File: rtl/flow_dir_relay.sv
module flow_dir_relay
    import pfd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             v_neg,
    input  logic             i_neg,
    input  logic [WIN_W-1:0] win_len,
    input  logic [CNT_W-1:0] thresh,
    input  logic             trip_clr,
    output logic             trip,
    output logic             dir_fwd,
    output logic             win_done
);
    prod_e                   prod_w;
    logic                    win_end_w;
    logic signed [CNT_W-1:0] win_sum_w;

    pfd_sign_product u_prod (
        .v_neg (v_neg),
        .i_neg (i_neg),
        .prod  (prod_w)
    );

    pfd_integrator #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_integ (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .prod      (prod_w),
        .win_len   (win_len),
        .win_end   (win_end_w),
        .win_sum   (win_sum_w)
    );

    pfd_decide #(.CNT_W(CNT_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_end  (win_end_w),
        .win_sum  (win_sum_w),
        .thresh   (thresh),
        .trip_clr (trip_clr),
        .trip     (trip),
        .dir_fwd  (dir_fwd),
        .win_done (win_done)
    );

    p_done_needs_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(sample_en));
endmodule

// File: tb/test_flow_dir_relay.sv
module test_flow_dir_relay;
    localparam int CW   = 5;
    localparam int WW   = 6;
    localparam int MAXV = (1 << (CW-1)) - 1;
    localparam int MINV = -(1 << (CW-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0, v_neg = 1'b0, i_neg = 1'b0, trip_clr = 1'b0;
    logic [WW-1:0] win_len = '0;
    logic [CW-1:0] thresh = '0;
    logic trip, dir_fwd, win_done;

    int total = 0, bad = 0;
    int m_acc = 0, m_cnt = 0, m_wl = 1, m_thr = 0;
    bit m_trip = 0, m_dir = 1;

    always #2 clk = ~clk;

    flow_dir_relay #(.CNT_W(CW), .WIN_W(WW)) i_flow_dir_relay (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .v_neg(v_neg),
        .i_neg(i_neg), .win_len(win_len), .thresh(thresh), .trip_clr(trip_clr),
        .trip(trip), .dir_fwd(dir_fwd), .win_done(win_done));

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic configure(int wl, int thr);
        @(negedge clk);
        win_len = WW'(wl);
        thresh  = CW'(thr);
        m_wl = (wl == 0) ? 1 : wl;
        m_thr = thr;
        trip_clr = 1'b1;
        @(negedge clk);
        trip_clr = 1'b0;
        m_trip = 0;
        check("R7 clear", int'(trip), 0);
    endtask

    // One strobed sample; outputs are checked at the following negedge.
    task automatic smp(bit vn, bit in_n, bit clr, bit idle_after);
        bit last;
        if (vn == in_n) m_acc = (m_acc + 1 > MAXV) ? MAXV : m_acc + 1;   // R2, R3
        else            m_acc = (m_acc - 1 < MINV) ? MINV : m_acc - 1;
        m_cnt++;
        last = (m_cnt >= m_wl);
        if (clr) m_trip = 0;
        if (last) begin
            m_dir = (m_acc >= 0);
            if (m_acc < -m_thr) m_trip = 1;
            m_acc = 0;
            m_cnt = 0;
        end
        @(negedge clk);
        v_neg = vn; i_neg = in_n; sample_en = 1'b1; trip_clr = clr;
        @(negedge clk);
        sample_en = 1'b0; trip_clr = 1'b0;
        check("R4 win_done", int'(win_done), int'(last));
        check("R5 dir_fwd", int'(dir_fwd), int'(m_dir));
        check("R6/R7 trip", int'(trip), int'(m_trip));
        if (idle_after) begin
            v_neg = ~vn; i_neg = in_n;   // R8: ignored without strobe
            @(negedge clk);
            check("R4 no done idle", int'(win_done), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int wls[7] = '{0, 1, 3, 8, 16, 24, 40};
        int thrs[4] = '{0, 3, 10, 15};
        repeat (3) @(negedge clk);
        check("R1 trip", int'(trip), 0);
        check("R1 dir", int'(dir_fwd), 1);
        check("R1 done", int'(win_done), 0);
        rst_n = 1'b1;

        // Sweep: square waves of period 8 with every phase offset.
        for (int ph = 0; ph < 8; ph++) begin
            for (int w = 0; w < 7; w++) begin
                for (int t = 0; t < 4; t++) begin
                    configure(wls[w], thrs[t]);
                    for (int k = 0; k < 2 * m_wl; k++) begin
                        smp(((k % 8) >= 4), (((k + ph) % 8) >= 4), 1'b0, (k % 5) == 2);
                    end
                end
            end
        end

        // R3: 24 opposed then 16 agreeing -> clamped sum 0 (unclamped -8), thr 3.
        configure(40, 3);
        for (int k = 0; k < 24; k++) smp(1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 16; k++) smp(1'b1, 1'b1, 1'b0, 1'b0);
        check("R3 saturation dir", int'(dir_fwd), 1);
        check("R3 saturation trip", int'(trip), 0);

        // R7: trip latches over forward windows; clear coincident with set keeps it.
        configure(4, 0);
        for (int k = 0; k < 4; k++) smp(1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 tripped", int'(trip), 1);
        for (int k = 0; k < 8; k++) smp(1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 held", int'(trip), 1);
        for (int k = 0; k < 4; k++) smp(1'b1, 1'b0, (k == 3), 1'b0);
        check("R7 set wins over clear", int'(trip), 1);
        smp(1'b1, 1'b1, 1'b1, 1'b0);
        check("R7 clear mid-window", int'(trip), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule